// File: doc/BRIEF.md
# MSI Write-Back Snooping Cache Controller

This block is the coherence controller of one private, direct-mapped, write-back cache in a multiprocessor that shares a snooped bus. Each line holds one data word and one of three states. Invalid means there is no copy. Shared means a read-only copy that other caches may also hold. Modified means the only copy, which may be read and written. The processor side takes loads and stores and acknowledges each one with a single-cycle ready pulse. The bus side issues three kinds of request: read (fetch for reading), read-exclusive (fetch with ownership), and write-back (return a line to memory).

A snoop port carries transactions that other caches put on the bus. A snooped read-exclusive removes this cache's copy of the line. A snooped read or read-exclusive that hits a modified line raises `snp_supply` in the same cycle, which tells memory to stand aside. The controller then queues a write-back of the line and downgrades the line only after the write-back is granted. Requests are held on the bus until `bus_gnt`. A queued snoop write-back takes the bus ahead of any processor request. The surrounding system guarantees that `snp_valid` is never high in a cycle in which this cache is granted the bus.

Top module: `msi_snoop_cache`

## Requirements
- R1: After reset every line is invalid, and `bus_valid`, `cpu_ready` and `snp_supply` are low.
- R2: A load to an address whose line is invalid or holds another tag issues one read (`bus_cmd`=1) with the full address. The line becomes shared, and the returned word appears on `cpu_rdata` with the ready pulse.
- R3: A store to an invalid or shared line issues one read-exclusive (`bus_cmd`=2). The line becomes modified and holds the store data.
- R4: A load to a shared or modified line, and a store to a modified line, complete with a one-cycle `cpu_ready` pulse and no bus request.
- R5: A snooped read-exclusive (`snp_cmd`=2) that hits a shared line makes it invalid without a write-back, so the next load to it issues a read.
- R6: A snooped read (`snp_cmd`=1) that hits a modified line produces a write-back (`bus_cmd`=3) that carries the line's address and data. After that the line is shared: loads hit, and a store needs a read-exclusive.
- R7: A snooped read-exclusive that hits a modified line produces a write-back of the line and then leaves it invalid.
- R8: A store that hits a modified line does not change memory until a later write-back.
- R9: `snp_supply` is high exactly in a cycle where a snooped read or read-exclusive hits a modified line.
- R10: A miss on an index whose line is modified with another tag first writes back the old line, then fetches the new one.
- R11: While a snoop write-back is queued for an index, a processor access to that index is held without a ready pulse. It completes only after the write-back has been granted.
- R12: When a store hit and a snoop to the same modified line fall in the same cycle, the store is ordered first, and the write-back carries the stored word.
- R13: A snoop whose tag does not match the held line changes nothing: there is no supply, no write-back and no state change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | AW | Word address |
| cpu_wdata | input | DW | Store data |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DW | Load data, valid with `cpu_ready` |
| bus_valid | output | 1 | Bus request pending |
| bus_cmd | output | 2 | 1 read, 2 read-exclusive, 3 write-back |
| bus_addr | output | AW | Request address |
| bus_wdata | output | DW | Write-back data |
| bus_gnt | input | 1 | Request accepted this cycle |
| bus_rvalid | input | 1 | Fill data valid |
| bus_rdata | input | DW | Fill data |
| snp_valid | input | 1 | Another cache's transaction is visible |
| snp_cmd | input | 2 | Snooped command, same encoding as `bus_cmd` |
| snp_addr | input | AW | Snooped address |
| snp_supply | output | 1 | This cache owns the data; memory must not answer |

## Verification
The processor sequencer and the snoop logic both act on the line array. The sharpest collision is a store hit on a modified line in the same cycle as a snooped read-exclusive to that line. The bench raises both requests on one falling edge. It then judges the ordering at the ports: the ready pulse must come on the next cycle, `snp_supply` must be high, the write-back must carry the newly stored word, and a later load must miss. A second collision is held open on purpose: the bench withholds the grant of a snoop write-back while a load to the same index waits. It expects no ready pulse until the grant is given.

// File: rtl/msi_pkg.sv
package msi_pkg;
   typedef enum logic [1:0] {
      LN_I = 2'd0,
      LN_S = 2'd1,
      LN_M = 2'd2
   } line_st_t;

   typedef enum logic [1:0] {
      BC_NONE = 2'd0,
      BC_RD   = 2'd1,
      BC_RDX  = 2'd2,
      BC_WB   = 2'd3
   } bus_cmd_t;
endpackage

// File: rtl/msi_line_store.sv
module msi_line_store
   import msi_pkg::*;
#(
   parameter int NLINES = 4,
   parameter int TW     = 6,
   parameter int DW     = 16
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          p_data_we,
   input  logic [$clog2(NLINES)-1:0]     p_idx,
   input  logic [TW-1:0]                 p_tag,
   input  logic [DW-1:0]                 p_data,
   input  logic                          p_st_we,
   input  line_st_t                      p_st,
   input  logic [NLINES-1:0]             s_st_we,
   input  line_st_t [NLINES-1:0]         s_st,
   output logic [NLINES-1:0][TW-1:0]     tag_o,
   output logic [NLINES-1:0][DW-1:0]     data_o,
   output line_st_t [NLINES-1:0]         st_o
);
   localparam int IW = $clog2(NLINES);

   for (genvar g = 0; g < NLINES; g++) begin : g_line
      line_st_t      st_q;
      logic [TW-1:0] tag_q;
      logic [DW-1:0] data_q;
      logic          sel;

      assign sel = (p_idx == IW'(g));

      // snoop updates first, processor updates win when both touch a line
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            st_q   <= LN_I;
            tag_q  <= '0;
            data_q <= '0;
         end else begin
            if (s_st_we[g])      st_q <= s_st[g];
            if (p_st_we && sel)  st_q <= p_st;
            if (p_data_we && sel) begin
               tag_q  <= p_tag;
               data_q <= p_data;
            end
         end
      end

      assign st_o[g]   = st_q;
      assign tag_o[g]  = tag_q;
      assign data_o[g] = data_q;
   end
endmodule

// File: rtl/msi_snoop.sv
module msi_snoop
   import msi_pkg::*;
#(
   parameter int NLINES = 4,
   parameter int AW     = 8,
   parameter int DW     = 16
) (
   input  logic                                       clk,
   input  logic                                       rst_n,
   input  logic                                       snp_valid,
   input  logic [1:0]                                 snp_cmd,
   input  logic [AW-1:0]                              snp_addr,
   input  logic [NLINES-1:0][AW-$clog2(NLINES)-1:0]   tag_i,
   input  logic [NLINES-1:0][DW-1:0]                  data_i,
   input  line_st_t [NLINES-1:0]                      st_i,
   input  logic                                       bus_gnt,
   output logic                                       snp_supply,
   output logic [NLINES-1:0]                          pend_o,
   output logic                                       wb_req,
   output logic [AW-1:0]                              wb_addr,
   output logic [DW-1:0]                              wb_data,
   output logic [NLINES-1:0]                          s_st_we,
   output line_st_t [NLINES-1:0]                      s_st
);
   localparam int IW = $clog2(NLINES);
   localparam int TW = AW - IW;

   logic [IW-1:0]     s_idx;
   logic [TW-1:0]     s_tag;
   logic              s_match, s_fetch, s_take_m, s_kill_s;
   logic [NLINES-1:0] pend_q, to_inv_q;
   logic [IW-1:0]     wb_idx;
   logic              wb_fire;

   assign s_idx    = snp_addr[IW-1:0];
   assign s_tag    = snp_addr[AW-1:IW];
   assign s_match  = snp_valid && (st_i[s_idx] != LN_I) && (tag_i[s_idx] == s_tag);
   assign s_fetch  = (snp_cmd == BC_RD) || (snp_cmd == BC_RDX);
   assign s_take_m = s_match && s_fetch && (st_i[s_idx] == LN_M);
   assign s_kill_s = s_match && (snp_cmd == BC_RDX) && (st_i[s_idx] == LN_S);
   assign snp_supply = s_take_m;

   // lowest queued index owns the bus first
   always_comb begin
      wb_idx = '0;
      for (int i = NLINES - 1; i >= 0; i--)
         if (pend_q[i]) wb_idx = IW'(i);
   end

   assign wb_req  = |pend_q;
   assign wb_fire = wb_req && bus_gnt;
   assign wb_addr = {tag_i[wb_idx], wb_idx};
   assign wb_data = data_i[wb_idx];
   assign pend_o  = pend_q;

   always_comb begin
      for (int i = 0; i < NLINES; i++) begin
         s_st_we[i] = 1'b0;
         s_st[i]    = LN_I;
         if (wb_fire && (wb_idx == IW'(i))) begin
            s_st_we[i] = 1'b1;
            s_st[i]    = to_inv_q[i] ? LN_I : LN_S;
         end
         if (s_kill_s && (s_idx == IW'(i))) begin
            s_st_we[i] = 1'b1;
            s_st[i]    = LN_I;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q   <= '0;
         to_inv_q <= '0;
      end else begin
         for (int i = 0; i < NLINES; i++) begin
            if (wb_fire && (wb_idx == IW'(i))) pend_q[i] <= 1'b0;
            if (s_take_m && (s_idx == IW'(i))) begin
               pend_q[i]   <= 1'b1;
               to_inv_q[i] <= (pend_q[i] && to_inv_q[i]) || (snp_cmd == BC_RDX);
            end
         end
      end
   end
endmodule

// File: rtl/msi_proc_fsm.sv
module msi_proc_fsm
   import msi_pkg::*;
#(
   parameter int NLINES = 4,
   parameter int AW     = 8,
   parameter int DW     = 16
) (
   input  logic                                       clk,
   input  logic                                       rst_n,
   input  logic                                       cpu_req,
   input  logic                                       cpu_we,
   input  logic [AW-1:0]                              cpu_addr,
   input  logic [DW-1:0]                              cpu_wdata,
   output logic                                       cpu_ready,
   output logic [DW-1:0]                              cpu_rdata,
   input  logic [NLINES-1:0][AW-$clog2(NLINES)-1:0]   tag_i,
   input  logic [NLINES-1:0][DW-1:0]                  data_i,
   input  line_st_t [NLINES-1:0]                      st_i,
   input  logic [NLINES-1:0]                          pend_i,
   input  logic                                       own_gnt,
   input  logic                                       bus_rvalid,
   input  logic [DW-1:0]                              bus_rdata,
   output logic                                       p_req,
   output logic [1:0]                                 p_cmd,
   output logic [AW-1:0]                              p_addr,
   output logic [DW-1:0]                              p_bus_data,
   output logic                                       p_data_we,
   output logic [$clog2(NLINES)-1:0]                  p_idx,
   output logic [AW-$clog2(NLINES)-1:0]               p_tag,
   output logic [DW-1:0]                              p_wdata,
   output logic                                       p_st_we,
   output line_st_t                                   p_st,
   output logic                                       idle_o
);
   localparam int IW = $clog2(NLINES);
   localparam int TW = AW - IW;

   typedef enum logic [2:0] {PS_IDLE, PS_EVICT, PS_FETCH, PS_WAIT, PS_RESP} ps_t;

   ps_t           ps_q, ps_d;
   logic          r_we;
   logic [AW-1:0] r_addr;
   logic [DW-1:0] r_wdata;
   logic          rdy_d, rdy_q;
   logic [DW-1:0] rdat_d, rdat_q;
   logic [IW-1:0] c_idx, r_idx;
   logic [TW-1:0] c_tag, r_tag;
   logic          c_hit, accept;

   assign c_idx  = cpu_addr[IW-1:0];
   assign c_tag  = cpu_addr[AW-1:IW];
   assign r_idx  = r_addr[IW-1:0];
   assign r_tag  = r_addr[AW-1:IW];
   assign c_hit  = (st_i[c_idx] != LN_I) && (tag_i[c_idx] == c_tag);
   assign accept = (ps_q == PS_IDLE) && cpu_req && !pend_i[c_idx];
   assign idle_o = (ps_q == PS_IDLE);

   always_comb begin
      ps_d       = ps_q;
      rdy_d      = 1'b0;
      rdat_d     = rdat_q;
      p_req      = 1'b0;
      p_cmd      = BC_NONE;
      p_addr     = r_addr;
      p_bus_data = data_i[r_idx];
      p_data_we  = 1'b0;
      p_idx      = r_idx;
      p_tag      = r_tag;
      p_wdata    = r_wdata;
      p_st_we    = 1'b0;
      p_st       = LN_I;
      unique case (ps_q)
         PS_IDLE: if (accept) begin
            if (c_hit && (!cpu_we || st_i[c_idx] == LN_M)) begin
               p_idx     = c_idx;
               p_tag     = c_tag;
               p_wdata   = cpu_wdata;
               p_data_we = cpu_we;
               rdat_d    = data_i[c_idx];
               rdy_d     = 1'b1;
               ps_d      = PS_RESP;
            end else if (!c_hit && st_i[c_idx] == LN_M) begin
               ps_d = PS_EVICT;
            end else begin
               ps_d = PS_FETCH;
            end
         end
         PS_EVICT: begin
            if (st_i[r_idx] != LN_M) begin
               ps_d = PS_FETCH;
            end else if (!pend_i[r_idx]) begin
               p_req  = 1'b1;
               p_cmd  = BC_WB;
               p_addr = {tag_i[r_idx], r_idx};
               if (own_gnt) begin
                  p_st_we = 1'b1;
                  p_st    = LN_I;
                  ps_d    = PS_FETCH;
               end
            end
         end
         PS_FETCH: begin
            p_req = 1'b1;
            p_cmd = r_we ? BC_RDX : BC_RD;
            if (own_gnt) ps_d = PS_WAIT;
         end
         PS_WAIT: if (bus_rvalid) begin
            p_data_we = 1'b1;
            p_wdata   = r_we ? r_wdata : bus_rdata;
            p_st_we   = 1'b1;
            p_st      = r_we ? LN_M : LN_S;
            rdat_d    = bus_rdata;
            rdy_d     = 1'b1;
            ps_d      = PS_RESP;
         end
         default: ps_d = PS_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ps_q    <= PS_IDLE;
         r_we    <= 1'b0;
         r_addr  <= '0;
         r_wdata <= '0;
         rdy_q   <= 1'b0;
         rdat_q  <= '0;
      end else begin
         ps_q   <= ps_d;
         rdy_q  <= rdy_d;
         rdat_q <= rdat_d;
         if (accept) begin
            r_we    <= cpu_we;
            r_addr  <= cpu_addr;
            r_wdata <= cpu_wdata;
         end
      end
   end

   assign cpu_ready = rdy_q;
   assign cpu_rdata = rdat_q;
endmodule

// File: rtl/msi_snoop_cache.sv
module msi_snoop_cache
   import msi_pkg::*;
#(
   parameter int NLINES = 4,
   parameter int AW     = 8,
   parameter int DW     = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cpu_req,
   input  logic          cpu_we,
   input  logic [AW-1:0] cpu_addr,
   input  logic [DW-1:0] cpu_wdata,
   output logic          cpu_ready,
   output logic [DW-1:0] cpu_rdata,
   output logic          bus_valid,
   output logic [1:0]    bus_cmd,
   output logic [AW-1:0] bus_addr,
   output logic [DW-1:0] bus_wdata,
   input  logic          bus_gnt,
   input  logic          bus_rvalid,
   input  logic [DW-1:0] bus_rdata,
   input  logic          snp_valid,
   input  logic [1:0]    snp_cmd,
   input  logic [AW-1:0] snp_addr,
   output logic          snp_supply
);
   localparam int IW = $clog2(NLINES);
   localparam int TW = AW - IW;

   if (NLINES < 2 || (NLINES & (NLINES - 1)) != 0) begin : g_bad_lines
      $error("NLINES must be a power of two of at least 2");
   end
   if (AW <= IW) begin : g_bad_aw
      $error("AW must exceed the index width");
   end
   if (DW < 1) begin : g_bad_dw
      $error("DW must be positive");
   end

   logic [NLINES-1:0][TW-1:0] tag_vec;
   logic [NLINES-1:0][DW-1:0] data_vec;
   line_st_t [NLINES-1:0]     st_vec;
   logic [NLINES-1:0]         pend, s_st_we;
   line_st_t [NLINES-1:0]     s_st;
   logic                      wb_req;
   logic [AW-1:0]             wb_addr, p_addr;
   logic [DW-1:0]             wb_data, p_bus_data, p_wdata;
   logic                      p_req, p_data_we, p_st_we, proc_idle, own_gnt;
   logic [1:0]                p_cmd;
   logic [IW-1:0]             p_idx;
   logic [TW-1:0]             p_tag;
   line_st_t                  p_st;

   // a queued snoop write-back owns the bus before the processor path
   assign own_gnt   = bus_gnt && !wb_req;
   assign bus_valid = wb_req || p_req;
   assign bus_cmd   = wb_req ? BC_WB : p_cmd;
   assign bus_addr  = wb_req ? wb_addr : p_addr;
   assign bus_wdata = wb_req ? wb_data : p_bus_data;

   msi_line_store #(.NLINES(NLINES), .TW(TW), .DW(DW)) u_store (
      .clk(clk), .rst_n(rst_n),
      .p_data_we(p_data_we), .p_idx(p_idx), .p_tag(p_tag), .p_data(p_wdata),
      .p_st_we(p_st_we), .p_st(p_st),
      .s_st_we(s_st_we), .s_st(s_st),
      .tag_o(tag_vec), .data_o(data_vec), .st_o(st_vec)
   );

   msi_snoop #(.NLINES(NLINES), .AW(AW), .DW(DW)) u_snoop (
      .clk(clk), .rst_n(rst_n),
      .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
      .tag_i(tag_vec), .data_i(data_vec), .st_i(st_vec), .bus_gnt(bus_gnt),
      .snp_supply(snp_supply), .pend_o(pend),
      .wb_req(wb_req), .wb_addr(wb_addr), .wb_data(wb_data),
      .s_st_we(s_st_we), .s_st(s_st)
   );

   msi_proc_fsm #(.NLINES(NLINES), .AW(AW), .DW(DW)) u_proc (
      .clk(clk), .rst_n(rst_n),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
      .tag_i(tag_vec), .data_i(data_vec), .st_i(st_vec), .pend_i(pend),
      .own_gnt(own_gnt), .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata),
      .p_req(p_req), .p_cmd(p_cmd), .p_addr(p_addr), .p_bus_data(p_bus_data),
      .p_data_we(p_data_we), .p_idx(p_idx), .p_tag(p_tag), .p_wdata(p_wdata),
      .p_st_we(p_st_we), .p_st(p_st), .idle_o(proc_idle)
   );
endmodule

// File: rtl/msi_snoop_cache_chk.sv
module msi_snoop_cache_chk
   import msi_pkg::*;
#(
   parameter int NLINES = 4,
   parameter int AW     = 8
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  cpu_req,
   input logic [AW-1:0]         cpu_addr,
   input logic                  cpu_ready,
   input logic                  bus_valid,
   input logic [1:0]            bus_cmd,
   input logic                  snp_valid,
   input logic [1:0]            snp_cmd,
   input logic                  snp_supply,
   input logic [NLINES-1:0]     pend,
   input line_st_t [NLINES-1:0] st_vec,
   input logic                  proc_idle
);
   localparam int IW = $clog2(NLINES);

   logic pend_on_m;
   always_comb begin
      pend_on_m = 1'b1;
      for (int i = 0; i < NLINES; i++)
         if (pend[i] && st_vec[i] != LN_M) pend_on_m = 1'b0;
   end

   AST_SUPPLY_NEEDS_SNOOP: assert property (@(posedge clk) disable iff (!rst_n)
      snp_supply |-> (snp_valid && snp_cmd != BC_WB && snp_cmd != BC_NONE)); // R9
   AST_READY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ready |=> !cpu_ready); // R4
   AST_CMD_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid |-> (bus_cmd != BC_NONE)); // R2
   AST_PEND_IS_MODIFIED: assert property (@(posedge clk) disable iff (!rst_n)
      pend_on_m); // R6
   AST_SUPPLY_QUEUES_WB: assert property (@(posedge clk) disable iff (!rst_n)
      snp_supply |=> (|pend && bus_valid)); // R7
   AST_STALL_SAME_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req && proc_idle && pend[cpu_addr[IW-1:0]]) |=> !cpu_ready); // R11
endmodule

bind msi_snoop_cache msi_snoop_cache_chk #(.NLINES(NLINES), .AW(AW)) u_chk (
   .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_addr(cpu_addr),
   .cpu_ready(cpu_ready), .bus_valid(bus_valid), .bus_cmd(bus_cmd),
   .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_supply(snp_supply),
   .pend(pend), .st_vec(st_vec), .proc_idle(proc_idle)
);

// File: tb/sim_msi_snoop_cache.sv
`timescale 1ns/1ps
module sim_msi_snoop_cache;
   localparam int AW = 8;
   localparam int DW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cpu_req = 1'b0, cpu_we = 1'b0;
   logic [AW-1:0] cpu_addr = '0;
   logic [DW-1:0] cpu_wdata = '0;
   logic          cpu_ready;
   logic [DW-1:0] cpu_rdata;
   logic          bus_valid;
   logic [1:0]    bus_cmd;
   logic [AW-1:0] bus_addr;
   logic [DW-1:0] bus_wdata;
   logic          bus_gnt = 1'b0, bus_rvalid = 1'b0;
   logic [DW-1:0] bus_rdata = '0;
   logic          snp_valid = 1'b0;
   logic [1:0]    snp_cmd = '0;
   logic [AW-1:0] snp_addr = '0;
   logic          snp_supply;

   always #2.5 clk = ~clk;

   msi_snoop_cache #(.NLINES(4), .AW(AW), .DW(DW)) u0 (
      .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
      .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready),
      .cpu_rdata(cpu_rdata), .bus_valid(bus_valid), .bus_cmd(bus_cmd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_gnt(bus_gnt),
      .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata), .snp_valid(snp_valid),
      .snp_cmd(snp_cmd), .snp_addr(snp_addr), .snp_supply(snp_supply)
   );

   // memory model and transaction log
   logic [DW-1:0] mem [256];
   int            log_cmd [64];
   int            log_addr [64];
   int            log_data [64];
   int            log_n = 0;
   logic          hold_gnt = 1'b0;
   logic          rsp_pend = 1'b0;
   logic [AW-1:0] rsp_addr = '0;

   function automatic logic [DW-1:0] init_val(input int a);
      return DW'(a * 259 + 17);
   endfunction

   always @(negedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 256; i++) mem[i] <= init_val(i);
         bus_gnt <= 1'b0; bus_rvalid <= 1'b0; rsp_pend <= 1'b0;
      end else begin
         bus_rvalid <= rsp_pend;
         if (rsp_pend) bus_rdata <= mem[rsp_addr];
         rsp_pend <= 1'b0;
         if (bus_valid && !hold_gnt) begin
            bus_gnt <= 1'b1;
            if (log_n < 64) begin
               log_cmd[log_n]  <= int'(bus_cmd);
               log_addr[log_n] <= int'(bus_addr);
               log_data[log_n] <= int'(bus_wdata);
            end
            log_n <= log_n + 1;
            if (bus_cmd == 2'd3) mem[bus_addr] <= bus_wdata;
            else begin rsp_pend <= 1'b1; rsp_addr <= bus_addr; end
         end else begin
            bus_gnt <= 1'b0;
         end
      end
   end

   int total = 0, bad = 0;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cpu_op(input bit we, input int a, input int d, output int q, output int cyc);
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = we; cpu_addr = AW'(a); cpu_wdata = DW'(d);
      cyc = 0;
      do begin @(negedge clk); cyc++; end while (!cpu_ready && cyc < 60);
      q = int'(cpu_rdata);
      cpu_req = 1'b0;
   endtask

   task automatic snoop(input int cmd, input int a, output bit sup);
      @(negedge clk);
      snp_valid = 1'b1; snp_cmd = 2'(cmd); snp_addr = AW'(a);
      #1 sup = snp_supply;
      @(negedge clk);
      snp_valid = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic t_reset();
      check(!cpu_ready && !bus_valid && !snp_supply, "R1", {cpu_ready, bus_valid, snp_supply}, 0);
   endtask

   task automatic t_load_miss();
      int q, c, n0;
      n0 = log_n;
      cpu_op(0, 'h10, 0, q, c);
      check(log_n == n0 + 1 && log_cmd[n0] == 1 && log_addr[n0] == 'h10, "R2", log_cmd[n0], 1);
      check(q == int'(init_val('h10)), "R2", q, int'(init_val('h10)));
   endtask

   task automatic t_hits();
      int q, c, n0;
      n0 = log_n;
      cpu_op(0, 'h10, 0, q, c);
      check(log_n == n0 && c == 1, "R4", log_n - n0, 0);
      cpu_op(1, 'h10, 'hBEEF, q, c);
      check(log_n == n0 + 1 && log_cmd[n0] == 2 && log_addr[n0] == 'h10, "R3", log_cmd[n0], 2);
      n0 = log_n;
      cpu_op(0, 'h10, 0, q, c);
      check(q == 'hBEEF && log_n == n0, "R4", q, 'hBEEF);
      cpu_op(1, 'h10, 'h1234, q, c);
      check(log_n == n0 && c == 1, "R4", log_n - n0, 0);
      check(mem['h10] == init_val('h10), "R8", int'(mem['h10]), int'(init_val('h10)));
   endtask

   task automatic t_snoop_rd_mod();
      int q, c, n0; bit s;
      n0 = log_n;
      snoop(1, 'h10, s);
      check(s, "R9", s, 1);
      check(log_n == n0 + 1 && log_cmd[n0] == 3 && log_addr[n0] == 'h10 && log_data[n0] == 'h1234,
            "R6", log_data[n0], 'h1234);
      n0 = log_n;
      cpu_op(0, 'h10, 0, q, c);
      check(q == 'h1234 && log_n == n0, "R6", q, 'h1234);
      cpu_op(1, 'h10, 'h4321, q, c);
      check(log_n == n0 + 1 && log_cmd[n0] == 2, "R6", log_cmd[n0], 2);
   endtask

   task automatic t_snoop_rdx();
      int q, c, n0; bit s;
      n0 = log_n;
      snoop(2, 'h10, s);
      check(s && log_n == n0 + 1 && log_cmd[n0] == 3 && log_data[n0] == 'h4321, "R7", log_data[n0], 'h4321);
      n0 = log_n;
      cpu_op(0, 'h10, 0, q, c);
      check(log_n == n0 + 1 && log_cmd[n0] == 1 && q == 'h4321, "R7", q, 'h4321);
      n0 = log_n;
      snoop(2, 'h10, s);
      check(!s && log_n == n0, "R5", s, 0);
      cpu_op(0, 'h10, 0, q, c);
      check(log_n == n0 + 1 && log_cmd[n0] == 1, "R5", log_n - n0, 1);
   endtask

   task automatic t_other_tag();
      int q, c, n0; bit s;
      n0 = log_n;
      snoop(2, 'h20, s);
      check(!s && log_n == n0, "R13", s, 0);
      cpu_op(0, 'h10, 0, q, c);
      check(log_n == n0 && q == 'h4321, "R13", q, 'h4321);
   endtask

   task automatic t_evict();
      int q, c, n0;
      cpu_op(1, 'h21, 'h7777, q, c);
      n0 = log_n;
      cpu_op(0, 'h31, 0, q, c);
      check(log_n == n0 + 2 && log_cmd[n0] == 3 && log_addr[n0] == 'h21 && log_data[n0] == 'h7777,
            "R10", log_addr[n0], 'h21);
      check(log_cmd[n0+1] == 1 && log_addr[n0+1] == 'h31 && q == int'(init_val('h31)), "R10", q, int'(init_val('h31)));
   endtask

   task automatic t_stall();
      int q, c, n0; bit s; bit early;
      cpu_op(1, 'h12, 'h0A0A, q, c);
      hold_gnt = 1'b1;
      @(negedge clk);
      snp_valid = 1'b1; snp_cmd = 2'd1; snp_addr = 8'h12;
      #1 s = snp_supply;
      @(negedge clk);
      snp_valid = 1'b0;
      n0 = log_n;
      cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 8'h12;
      early = 1'b0;
      repeat (6) begin @(negedge clk); if (cpu_ready) early = 1'b1; end
      check(s && !early, "R11", early, 0);
      hold_gnt = 1'b0;
      c = 0;
      do begin @(negedge clk); c++; end while (!cpu_ready && c < 60);
      q = int'(cpu_rdata);
      cpu_req = 1'b0;
      check(log_n == n0 + 1 && log_cmd[n0] == 3 && log_data[n0] == 'h0A0A, "R11", log_n - n0, 1);
      check(q == 'h0A0A, "R11", q, 'h0A0A);
   endtask

   task automatic t_same_cycle();
      int q, c, n0; bit s, rdy;
      cpu_op(1, 'h12, 'h5555, q, c);
      n0 = log_n;
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = 8'h12; cpu_wdata = 16'h6666;
      snp_valid = 1'b1; snp_cmd = 2'd2; snp_addr = 8'h12;
      #1 s = snp_supply;
      @(negedge clk);
      rdy = cpu_ready;
      snp_valid = 1'b0; cpu_req = 1'b0;
      repeat (3) @(negedge clk);
      check(s && rdy, "R12", {s, rdy}, 3);
      check(log_n == n0 + 1 && log_cmd[n0] == 3 && log_data[n0] == 'h6666, "R12", log_data[n0], 'h6666);
      n0 = log_n;
      cpu_op(0, 'h12, 0, q, c);
      check(log_n == n0 + 1 && log_cmd[n0] == 1 && q == 'h6666, "R12", q, 'h6666);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_load_miss();
      t_hits();
      t_snoop_rd_mod();
      t_snoop_rdx();
      t_other_tag();
      t_evict();
      t_stall();
      t_same_cycle();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule